// File: doc/BRIEF.md
# Edge-to-Level Interrupt Request Latch

This block gathers short edge events from several sources and turns them into one active-low, level-sensitive interrupt request for a processor. Each source has its own pending latch. The latch sets on that source's active edge, but only while the source is enabled. The request line is driven low while any enabled source has its latch set. A latch stays set until the processor clears it. A source that stays at its active level after being cleared does not set the latch again, so one edge gives exactly one interrupt.

There are two ways to clear a latch. An acknowledge strobe clears every latch whose bit is set in a select mask. A read strobe on the data port clears the latch of the source that owns the data port. When that source's edge is latched, the block stores the 8-bit cause code that the device presents on the data-port input. The data-port output then shows that stored code, so a read both delivers the cause and drops the request. The pending latches are visible as a plain status vector, and observing it changes nothing. The default build has four sources, and source 0 owns the data port.

Top module: `irq_edge_latch`

## Requirements
- R1: After reset, `status` is all zeros, `irq_n` is 1 and `port_dout` is 0.
- R2: Bit i of `status` belongs to source i. An active edge on an enabled source sets its bit at the clock edge where the new level is first sampled. With the default `EDGE_POL` of 4'b0111, sources 0 to 2 are active on a rising edge and source 3 is active on a falling edge (idle high).
- R3: `irq_n` is 0 exactly when at least one `status` bit is set and that source's `src_en` bit is 1. Clearing an enable raises `irq_n` but keeps the latch set. Setting the enable again drives `irq_n` low again.
- R4: An edge on a source whose `src_en` bit is 0 leaves that `status` bit at 0 and leaves `irq_n` at 1.
- R5: When `ack_stb` is 1, every latch whose `ack_sel` bit is 1 is cleared at the next clock edge. Latches whose `ack_sel` bit is 0 are not affected.
- R6: When `port_rd` is 1, the latch of source 0 is cleared at the next clock edge. `port_dout` shows the cause code that was stored for that source.
- R7: `port_din` is stored when an edge of source 0 is latched. Later changes on `port_din` do not alter `port_dout`.
- R8: If a source's edge arrives in the same cycle as a clear of that source, by either strobe, the latch stays set. In the port-owner case, the new code is stored.
- R9: A set latch holds its value for any number of cycles while no clear is applied.
- R10: A source that stays at its active level after its latch is cleared does not set the latch again until it leaves that level and returns to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Source event inputs |
| src_en | input | NSRC | Per-source enable mask |
| ack_stb | input | 1 | Acknowledge strobe |
| ack_sel | input | NSRC | Latches cleared by the acknowledge strobe |
| port_rd | input | 1 | Data-port read strobe; clears the port-owner latch |
| port_din | input | CODE_W | Cause code from the device |
| port_dout | output | CODE_W | Stored cause code |
| status | output | NSRC | Pending latch bits |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The latch is driven with these input patterns:
- A single rising pulse, and a single falling pulse on the inverted-polarity source. Together they show that the polarity of each source is honoured.
- Two sources firing together and then being acknowledged one at a time. This separates the combining of sources into `irq_n` from the per-bit clear.
- An edge on a disabled source, and a pending source that is disabled and then enabled again. These separate masking at set time from masking of the request.
- An edge that coincides with a read and an acknowledge, and a source held at its active level after a clear. These separate edge detection from level detection and confirm that a set wins over a clear.

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int NSRC = 4,
  parameter int CODE_W = 8,
  parameter int CODE_SRC = 0,
  parameter logic [NSRC-1:0] EDGE_POL = 4'b0111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic [NSRC-1:0]   src_en,
  input  logic              ack_stb,
  input  logic [NSRC-1:0]   ack_sel,
  input  logic              port_rd,
  input  logic [CODE_W-1:0] port_din,
  output logic [CODE_W-1:0] port_dout,
  output logic [NSRC-1:0]   status,
  output logic              irq_n
);

  logic [NSRC-1:0]   act_lvl, prev_q, edge_v, rd_v, clr_v, pend_q;
  logic [CODE_W-1:0] code_q;

  assign act_lvl = ~(src_in ^ EDGE_POL);
  assign edge_v  = act_lvl & ~prev_q & src_en;
  assign rd_v    = {{(NSRC-1){1'b0}}, port_rd} << CODE_SRC;
  assign clr_v   = ({NSRC{ack_stb}} & ack_sel) | rd_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      pend_q <= '0;
      code_q <= '0;
    end else begin
      prev_q <= act_lvl;
      pend_q <= (pend_q & ~clr_v) | edge_v;
      if (edge_v[CODE_SRC]) code_q <= port_din;
    end
  end

  assign status    = pend_q;
  assign port_dout = code_q;
  assign irq_n     = ~|(pend_q & src_en);

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    AST_SET_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      edge_v[i] |=> status[i]); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_stb && ack_sel[i] && !edge_v[i] |=> !status[i]); // R5
    AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
      status[i] && !clr_v[i] |=> status[i]); // R9
    AST_DIS_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !src_en[i] && !status[i] |=> !status[i]); // R4
    AST_LEVEL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      prev_q[i] && act_lvl[i] && !status[i] |=> !status[i]); // R10
  end

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd && !edge_v[CODE_SRC] |=> !status[CODE_SRC]); // R6
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_v[CODE_SRC] |=> $stable(port_dout)); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(|edge_v) || (src_en != $past(src_en)))); // R3

endmodule

// File: tb/sim_irq_edge_latch.sv
module sim_irq_edge_latch;
  logic       clk = 0, rst_n = 0;
  logic [3:0] src_in = 4'b1000, src_en = 4'b0000, ack_sel = 4'b0000;
  logic       ack_stb = 0, port_rd = 0;
  logic [7:0] port_din = 8'h00;
  logic [7:0] port_dout;
  logic [3:0] status;
  logic       irq_n;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  irq_edge_latch u0 (.clk, .rst_n, .src_in, .src_en, .ack_stb, .ack_sel,
                     .port_rd, .port_din, .port_dout, .status, .irq_n);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ack(logic [3:0] sel);
    ack_stb = 1; ack_sel = sel; step(); ack_stb = 0; ack_sel = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 0);
    chk("R1 irq_n", irq_n, 1);
    chk("R1 port_dout", port_dout, 0);
  endtask

  task automatic t_single();
    src_en = 4'b1111; port_din = 8'hA5; src_in[0] = 1; step();
    chk("R2 rise status", status, 4'b0001);
    chk("R3 irq low", irq_n, 0);
    chk("R7 code", port_dout, 8'hA5);
    src_in[0] = 0; port_din = 8'h3C; step(); step(); step();
    chk("R9 held", status, 4'b0001);
    chk("R7 code kept", port_dout, 8'hA5);
    port_rd = 1; step(); port_rd = 0;
    chk("R6 rd clears", status, 0);
    chk("R6 irq high", irq_n, 1);
    chk("R6 code out", port_dout, 8'hA5);
  endtask

  task automatic t_falling();
    src_in[3] = 0; step();
    chk("R2 fall status", status, 4'b1000);
    src_in[3] = 1; step();
    ack(4'b1000);
    chk("R5 ack clears", status, 0);
  endtask

  task automatic t_multi();
    src_in[1] = 1; src_in[2] = 1; step(); src_in[1] = 0; src_in[2] = 0;
    chk("R3 two set", status, 4'b0110);
    ack(4'b0010);
    chk("R5 one cleared", status, 4'b0100);
    chk("R3 still low", irq_n, 0);
    ack(4'b0100);
    chk("R3 all clear", irq_n, 1);
  endtask

  task automatic t_disabled();
    src_en = 4'b1011; src_in[2] = 1; step(); src_in[2] = 0; step();
    chk("R4 no latch", status, 0);
    chk("R4 irq high", irq_n, 1);
    src_en = 4'b1111; src_in[1] = 1; step(); src_in[1] = 0;
    src_en = 4'b1101; step();
    chk("R3 masked irq", irq_n, 1);
    chk("R3 latch kept", status, 4'b0010);
    src_en = 4'b1111; #1;
    chk("R3 reenabled irq", irq_n, 0);
    ack(4'b0010);
  endtask

  task automatic t_collide();
    port_din = 8'h11; src_in[0] = 1; step(); src_in[0] = 0; step();
    src_in[0] = 1; port_din = 8'h22; port_rd = 1; ack_stb = 1; ack_sel = 4'b0001;
    step(); port_rd = 0; ack_stb = 0; ack_sel = 0; src_in[0] = 0;
    chk("R8 set wins", status, 4'b0001);
    chk("R8 new code", port_dout, 8'h22);
    port_rd = 1; step(); port_rd = 0;
    chk("R6 clear after collide", status, 0);
  endtask

  task automatic t_level_hold();
    src_in[1] = 1; step();
    chk("R10 first edge", status, 4'b0010);
    ack(4'b0010); step(); step(); step();
    chk("R10 no retrigger", status, 0);
    chk("R10 irq high", irq_n, 1);
    src_in[1] = 0; step(); src_in[1] = 1; step(); src_in[1] = 0;
    chk("R10 new edge", status, 4'b0010);
    ack(4'b0010);
  endtask

  initial begin
    #200_000ns;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1; step(); step();
    t_reset();
    rst_n = 1; step();
    t_reset();
    t_single();
    t_falling();
    t_multi();
    t_disabled();
    t_collide();
    t_level_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule